// File: doc/BRIEF.md
# Parallel I/O Controller with Two-Way Peripheral Routing

This block controls a bank of up to 31 bidirectional pads. Each pad is either driven by the controller's own output and output-enable state, or handed to one of two on-chip peripheral functions, called A and B. Every piece of per-line state is changed only by writing a 1 to the matching bit of a set address or a clear address. Software can therefore alter one line without a read-modify-write sequence and without disturbing the other lines.

The pad inputs pass through a two-flop synchronizer. A change detector on every line records a transition in a sticky status bit when that line's change detection is enabled. This works whichever function owns the line. Reading the status word returns the bits and clears them. A single interrupt output is high while any recorded change is also enabled.

The register port is a simple word-addressed read/write port. Read data is registered and appears in the cycle after the read strobe. Each state has three addresses: set at 3b, clear at 3b+1 and status at 3b+2. Here b is 0 for peripheral ownership, 1 for output enable, 2 for output level, 3 for peripheral select and 4 for change-detect enable. Address 15 holds the change status and address 16 holds the synchronized pad level. All other addresses read as zero.

Top module: `gpio_mux_ctl`

## Requirements
- R1: After reset, every state word (ownership, output enable, output level, select, change enable, change status) reads 0, pin_oe is all zeros and irq is low.
- R2: A write of a word to a set address (0, 3, 6, 9, 12) sets the state bits where the word has a 1 and leaves all other bits unchanged.
- R3: A write of a word to a clear address (1, 4, 7, 10, 13) clears the state bits where the word has a 1 and leaves all other bits unchanged.
- R4: A read of any set address, any clear address or an unmapped address returns zero.
- R5: On a line whose ownership bit is 0, pin_out follows the output-level state and pin_oe follows the output-enable state.
- R6: On a line whose ownership bit is 1, pin_out and pin_oe come from peripheral A when the select bit is 0 and from peripheral B when the select bit is 1.
- R7: A pad level change on a line with change detection enabled sets that line's status bit on the third rising clock edge after the change. A change on a disabled line sets nothing.
- R8: Change detection works in the same way on lines owned by a peripheral and on lines owned by the controller.
- R9: A read of the change status (address 15) returns the bits as they were and clears all of them. A change recorded on the same edge as the read stays set.
- R10: irq is high exactly when some status bit and its change-enable bit are both 1. Clearing the enable masks irq but keeps the status bit.
- R11: Address 16 reads the pad levels after the two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 5 | Word address for read or write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_en |
| pa_out | input | NLINES | Peripheral A output levels |
| pa_oe | input | NLINES | Peripheral A output enables |
| pb_out | input | NLINES | Peripheral B output levels |
| pb_oe | input | NLINES | Peripheral B output enables |
| pin_in | input | NLINES | Pad input levels (asynchronous) |
| pin_out | output | NLINES | Pad output levels |
| pin_oe | output | NLINES | Pad output enables |
| irq | output | 1 | Input-change interrupt |

## Verification
The bench builds the block with NLINES at its default of 31, so every line up to the top bit of the port is exercised. This includes routing patterns in which controller-owned, peripheral-A and peripheral-B lines sit next to each other in one word. At full width the same stimulus covers change detection on a controller-owned line and on a peripheral-owned line, a change on a disabled line, and a read that clears status on the same edge a new change is recorded.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 32;
  localparam int NBANKS   = 5;
  // bank order: ownership, output enable, output level, select, change enable
  localparam int BK_PEN   = 0;
  localparam int BK_OE    = 1;
  localparam int BK_OUT   = 2;
  localparam int BK_SEL   = 3;
  localparam int BK_IEN   = 4;
  localparam logic [ADDR_W-1:0] A_CHG = 5'd15;
  localparam logic [ADDR_W-1:0] A_PIN = 5'd16;

  function automatic logic [ADDR_W-1:0] set_addr(input int b);
    return ADDR_W'(3 * b);
  endfunction
  function automatic logic [ADDR_W-1:0] clr_addr(input int b);
    return ADDR_W'(3 * b + 1);
  endfunction
  function automatic logic [ADDR_W-1:0] stat_addr(input int b);
    return ADDR_W'(3 * b + 2);
  endfunction
endpackage

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] mask,
  output logic [W-1:0] state_q
);
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (set_en) state_d = state_d | mask;
    if (clr_en) state_d = state_d & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                state_q <= '0;
    else if (set_en || clr_en) state_q <= state_d;
  end
endmodule

// File: rtl/gpio_pin_route.sv
module gpio_pin_route #(
  parameter int W = 31
) (
  input  logic [W-1:0] pen,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] own_out,
  input  logic [W-1:0] own_oe,
  input  logic [W-1:0] pa_out,
  input  logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_out,
  input  logic [W-1:0] pb_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  for (genvar i = 0; i < W; i++) begin : g_line
    always_comb begin
      if (!pen[i]) begin
        pin_out[i] = own_out[i];
        pin_oe[i]  = own_oe[i];
      end else if (sel[i]) begin
        pin_out[i] = pb_out[i];
        pin_oe[i]  = pb_oe[i];
      end else begin
        pin_out[i] = pa_out[i];
        pin_oe[i]  = pa_oe[i];
      end
    end
  end
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] ien,
  input  logic         clr_all,
  output logic [W-1:0] pin_sync,
  output logic [W-1:0] chg_evt,
  output logic [W-1:0] chg_q
);
  logic [W-1:0] meta_q, prev_q, chg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      pin_sync <= '0;
      prev_q   <= '0;
    end else begin
      meta_q   <= pin_in;
      pin_sync <= meta_q;
      prev_q   <= pin_sync;
    end
  end

  assign chg_evt = (pin_sync ^ prev_q) & ien;

  always_comb begin
    chg_d = chg_q;
    if (clr_all) chg_d = '0;
    chg_d = chg_d | chg_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= '0;
    else        chg_q <= chg_d;
  end
endmodule

// File: rtl/gpio_mux_ctl.sv
module gpio_mux_ctl
  import gpio_mux_pkg::*;
#(
  parameter int NLINES = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [NLINES-1:0] pa_out,
  input  logic [NLINES-1:0] pa_oe,
  input  logic [NLINES-1:0] pb_out,
  input  logic [NLINES-1:0] pb_oe,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq
);
  localparam int W = NLINES;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [W-1:0] wmask;
  logic [W-1:0] bank_q [NBANKS];
  assign wmask = wr_data[W-1:0];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic set_en, clr_en;
    assign set_en = wr_en && (reg_addr == set_addr(b));
    assign clr_en = wr_en && (reg_addr == clr_addr(b));
    gpio_setclr_bank #(.W(W)) u_bank (
      .clk(clk), .rst_n(rst_sync_n), .set_en(set_en), .clr_en(clr_en),
      .mask(wmask), .state_q(bank_q[b])
    );
  end

  logic [W-1:0] pen_q, oe_q, out_q, sel_q, ien_q;
  assign pen_q = bank_q[BK_PEN];
  assign oe_q  = bank_q[BK_OE];
  assign out_q = bank_q[BK_OUT];
  assign sel_q = bank_q[BK_SEL];
  assign ien_q = bank_q[BK_IEN];

  gpio_pin_route #(.W(W)) u_route (
    .pen(pen_q), .sel(sel_q), .own_out(out_q), .own_oe(oe_q),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  logic         chg_rd;
  logic [W-1:0] pin_sync, chg_evt, chg_q;
  assign chg_rd = rd_en && (reg_addr == A_CHG);

  gpio_chg_detect #(.W(W)) u_chg (
    .clk(clk), .rst_n(rst_sync_n), .pin_in(pin_in), .ien(ien_q),
    .clr_all(chg_rd), .pin_sync(pin_sync), .chg_evt(chg_evt), .chg_q(chg_q)
  );

  assign irq = |(chg_q & ien_q);

  logic [31:0] rd_d;
  always_comb begin
    rd_d = '0;
    for (int b = 0; b < NBANKS; b++)
      if (reg_addr == stat_addr(b)) rd_d[W-1:0] = bank_q[b];
    if (reg_addr == A_CHG) rd_d[W-1:0] = chg_q;
    if (reg_addr == A_PIN) rd_d[W-1:0] = pin_sync;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_data <= '0;
    else if (rd_en)  rd_data <= rd_d;
  end
endmodule

// File: rtl/gpio_mux_ctl_chk.sv
module gpio_mux_ctl_chk #(
  parameter int W = 31
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         rd_en,
  input logic [4:0]   reg_addr,
  input logic [31:0]  wr_data,
  input logic [31:0]  rd_data,
  input logic [W-1:0] oe_q,
  input logic [W-1:0] out_q,
  input logic [W-1:0] pen_q,
  input logic [W-1:0] sel_q,
  input logic [W-1:0] ien_q,
  input logic [W-1:0] chg_q,
  input logic [W-1:0] chg_evt,
  input logic [W-1:0] pa_oe,
  input logic [W-1:0] pb_oe,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe
);
  // R2
  oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == 5'd3) |=> ((oe_q & $past(wr_data[W-1:0])) == $past(wr_data[W-1:0])));
  // R3
  oe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == 5'd4) |=> ((oe_q & $past(wr_data[W-1:0])) == '0));
  // R4
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr < 5'd15 && (reg_addr % 5'd3) != 5'd2) |=> (rd_data == '0));
  // R5
  own_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((((pin_out ^ out_q) | (pin_oe ^ oe_q)) & ~pen_q) == '0));
  // R6
  per_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((((pin_oe ^ pa_oe) & ~sel_q) | ((pin_oe ^ pb_oe) & sel_q)) & pen_q) == '0);
  // R7
  masked_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((chg_q & ~$past(chg_q) & ~$past(ien_q)) == '0));
  // R9
  chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr == 5'd15 && chg_evt == '0) |=> (chg_q == '0));
endmodule

bind gpio_mux_ctl gpio_mux_ctl_chk #(.W(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
  .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
  .oe_q(oe_q), .out_q(out_q), .pen_q(pen_q), .sel_q(sel_q), .ien_q(ien_q),
  .chg_q(chg_q), .chg_evt(chg_evt), .pa_oe(pa_oe), .pb_oe(pb_oe),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_mux_ctl_test.sv
module gpio_mux_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [N-1:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0, pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_ctl #(.NLINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_out(pb_out), .pb_oe(pb_oe), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: issue a read and push the expected word to the scoreboard
  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compare a read response one edge after the strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  function automatic logic [N-1:0] route_exp(input logic [N-1:0] pen, sel, own, a, b);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = !pen[i] ? own[i] : (sel[i] ? b[i] : a[i]);
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    check("watchdog expired", 32'h1, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] pen_m, sel_m, oe_m, out_m;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check("R1 pin_oe", 32'(pin_oe), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    for (int b = 0; b < 5; b++) rd(5'(3*b+2), 32'h0, "R1 state word");
    rd(5'd15, 32'h0, "R1 change status");

    // R2 set, R5 controller-owned drive
    wr(5'd3, 32'h0000_00F0);
    wr(5'd6, 32'h0000_00A0);
    rd(5'd5, 32'h0000_00F0, "R2 oe after set");
    wr(5'd3, 32'h4000_0003);
    rd(5'd5, 32'h4000_00F3, "R2 oe second set keeps others");
    check("R5 pin_oe", 32'(pin_oe), 32'h4000_00F3);
    check("R5 pin_out", 32'(pin_out), 32'h0000_00A0);

    // R3 clear
    wr(5'd4, 32'h0000_0030);
    rd(5'd5, 32'h4000_00C3, "R3 oe after clear");
    wr(5'd7, 32'h0000_0080);
    rd(5'd8, 32'h0000_0020, "R3 out after clear");

    // R4 set/clear/unmapped read zero
    rd(5'd3, 32'h0, "R4 set addr");
    rd(5'd4, 32'h0, "R4 clear addr");
    rd(5'd31, 32'h0, "R4 unmapped");

    // R6 peripheral routing, mixed with controller-owned lines
    pa_out = 31'h5555_5555; pa_oe = 31'h0F0F_0F0F;
    pb_out = 31'h2AAA_AAAA; pb_oe = 31'h7000_F000;
    wr(5'd0, 32'h4000_FF00);
    wr(5'd9, 32'h4000_F000);
    pen_m = 31'h4000_FF00; sel_m = 31'h4000_F000;
    oe_m = 31'h4000_00C3; out_m = 31'h0000_0020;
    idle(1);
    check("R6 pin_out", 32'(pin_out), 32'(route_exp(pen_m, sel_m, out_m, pa_out, pb_out)));
    check("R6 pin_oe", 32'(pin_oe), 32'(route_exp(pen_m, sel_m, oe_m, pa_oe, pb_oe)));
    rd(5'd2, 32'h4000_FF00, "R6 ownership state");

    // R11 synchronized pad level; R7 change on disabled lines sets nothing
    pin_in = 31'h1234_5678;
    idle(4);
    rd(5'd16, 32'h1234_5678, "R11 pad level");
    rd(5'd15, 32'h0, "R7 disabled lines record nothing");
    check("R7 irq with lines disabled", 32'(irq), 32'h0);

    // R7/R8 enabled lines: bit0 controller-owned, bit8 peripheral-owned
    wr(5'd12, 32'h0000_0101);
    pin_in = pin_in ^ 31'h0000_0103;
    idle(1);
    check("R7 not yet after one edge", 32'(irq), 32'h0);
    idle(3);
    check("R10 irq raised", 32'(irq), 32'h1);
    rd(5'd15, 32'h0000_0101, "R8 status on both owners");
    rd(5'd15, 32'h0, "R9 cleared by read");
    check("R9 irq after clear", 32'(irq), 32'h0);

    // R10 masking keeps status
    pin_in = pin_in ^ 31'h0000_0001;
    idle(4);
    check("R10 irq on bit0", 32'(irq), 32'h1);
    wr(5'd13, 32'h0000_0001);
    check("R10 irq masked", 32'(irq), 32'h0);
    rd(5'd15, 32'h0000_0001, "R10 status kept when masked");

    // R9 change recorded on the same edge as a clearing read
    wr(5'd12, 32'h0000_0004);
    pin_in = pin_in ^ 31'h0000_0004;
    idle(1);
    rd(5'd15, 32'h0, "R9 same-edge read sees old word");
    rd(5'd15, 32'h0000_0004, "R9 same-edge change kept");

    idle(2);
    if (exp_q.size() != 0) check("R9 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule